// File: doc/BRIEF.md
# Programmable Clock Divider Cell

This cell derives one output clock from a set of candidate sources. A two-level source selector picks the primary source or one of eight auxiliary sources. The chosen source drives a divider whose ratio comes from a small non-linear table, from a fixed divide-by-3 path, or from a straight bypass. An enable gate sits at the output and only ever switches while the divided clock is low. Software programs the cell through a small write port. Two outputs report the chosen source as a single flattened index and the effective divide ratio.

Every source arrives as an edge strobe that is sampled on the cell's own clock: a strobe high for one cycle stands for one edge of that source. The divided clock is an ordinary register that flips after every R edges of the chosen source, where R is the effective ratio. The output period is therefore R source periods with a 50% duty cycle, and this holds for the odd ratio 3 as well.

Two per-instance parameters can remove parts of the cell. `HAS_MUX` = 0 removes the source selector: only the primary source is used and the index reads 0. `HAS_GATE` = 0 removes the gate, and the output then runs freely.

Top module: `clkdiv_cell`

## Requirements
- R1: After reset, `parent_idx` reads 0, `eff_ratio` reads 1 and `clk_out` stays low, because the enable bit resets to 0.
- R2: A write to address 0 takes the flattened source index k from `cfg_wdata`. k = 0 clears the source switch. k from 1 to 8 sets the switch and loads k-1 into the auxiliary select. `parent_idx` reads k back in the cycle after the write. A value above 8 leaves `parent_idx` unchanged. A write to address 3 changes no output.
- R3: A write to address 1 sets three controls: the divider code in `cfg_wdata[2:0]`, the divider-on bit in `cfg_wdata[3]` and the divide-by-3 bit in `cfg_wdata[4]`. With the divide-by-3 bit clear and divider-on set, codes 0 to 7 give `eff_ratio` values 1, 2, 4, 6, 8, 12, 1, 1.
- R4: With the divide-by-3 bit set, `eff_ratio` is 3, whatever the other two controls hold.
- R5: With both the divide-by-3 bit and the divider-on bit clear, `eff_ratio` is 1.
- R6: `clk_out` holds each level for exactly R edges of the chosen source, where R is the effective ratio, so the duty cycle is 50%. It does not change in any cycle without an edge.
- R7: With index 0, the primary strobe drives the divider. With index k > 0, `aux_tick[k-1]` drives it. Strobes on sources that are not chosen have no effect.
- R8: A new ratio first takes effect on the level that starts after the current level completes. The level already in progress keeps the old length.
- R9: A write to address 2 sets the enable bit from `cfg_wdata[0]`, where 1 means running. While the bit is 0, `clk_out` stays low. Enabling or disabling never produces a high level shorter than R edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock; all registers and strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | Register address: 0 index, 1 divider, 2 enable, 3 spare |
| cfg_wdata | input | 8 | Write data |
| prim_tick | input | 1 | Edge strobe of the primary source |
| aux_tick | input | 8 | Edge strobes of the auxiliary sources |
| clk_out | output | 1 | Gated divided clock |
| parent_idx | output | 4 | Flattened index of the chosen source |
| eff_ratio | output | 4 | Effective divide ratio |

## Verification
A wrong latched ratio or a miscounting counter shows at `clk_out` as a level of the wrong length, which is visible within one period of at most 24 source edges. A wrong source route shows up as a frozen output, or as one that runs while only unchosen strobes toggle; it is seen within a few cycles. A gate register that is updated at the wrong phase cuts a high level short, and the next falling edge of `clk_out` exposes it. Readback errors in the index or the ratio appear in the cycle right after the write.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int RATIO_W = 4;
    localparam int CODE_W  = 3;

    typedef enum logic [1:0] {
        ADDR_PARENT = 2'd0,
        ADDR_DIV    = 2'd1,
        ADDR_GATE   = 2'd2,
        ADDR_SPARE  = 2'd3
    } cfg_addr_e;

    typedef struct packed {
        logic              div3;
        logic              div_on;
        logic [CODE_W-1:0] code;
    } div_ctl_t;

    function automatic logic [RATIO_W-1:0] code_ratio(input logic [CODE_W-1:0] c);
        logic [RATIO_W-1:0] r;
        case (c)
            3'd1:    r = 4'd2;
            3'd2:    r = 4'd4;
            3'd3:    r = 4'd6;
            3'd4:    r = 4'd8;
            3'd5:    r = 4'd12;
            default: r = 4'd1;
        endcase
        return r;
    endfunction

    function automatic logic [RATIO_W-1:0] pick_ratio(input div_ctl_t d);
        logic [RATIO_W-1:0] r;
        if (d.div3)
            r = 4'd3;
        else if (d.div_on)
            r = code_ratio(d.code);
        else
            r = 4'd1;
        return r;
    endfunction

endpackage

// File: rtl/clkdiv_cfg_regs.sv
module clkdiv_cfg_regs
    import clkdiv_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int DATA_W   = 8,
    parameter bit HAS_MUX  = 1'b1,
    parameter bit HAS_GATE = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [1:0]         addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               src_switch,
    output logic [SEL_W-1:0]   src_sel,
    output div_ctl_t           div_ctl,
    output logic               gate_req,
    output logic [SEL_W:0]     parent_idx
);
    localparam int IDX_W   = SEL_W + 1;
    localparam int NUM_AUX = 1 << SEL_W;

    logic [IDX_W-1:0] idx_in;
    logic             idx_ok;

    assign idx_in = wdata[IDX_W-1:0];
    assign idx_ok = (wdata[DATA_W-1:IDX_W] == '0) && (idx_in <= IDX_W'(NUM_AUX));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_ctl <= '0;
        end else if (we && cfg_addr_e'(addr) == ADDR_DIV) begin
            div_ctl <= div_ctl_t'(wdata[CODE_W+1:0]);
        end
    end

    generate
        if (HAS_MUX) begin : g_mux_regs
            always_ff @(posedge clk) begin
                if (rst) begin
                    src_switch <= 1'b0;
                    src_sel    <= '0;
                end else if (we && cfg_addr_e'(addr) == ADDR_PARENT && idx_ok) begin
                    if (idx_in == '0) begin
                        src_switch <= 1'b0;
                    end else begin
                        src_switch <= 1'b1;
                        src_sel    <= SEL_W'(idx_in - IDX_W'(1));
                    end
                end
            end
            assign parent_idx = src_switch ? ({1'b0, src_sel} + IDX_W'(1)) : '0;
        end else begin : g_no_mux_regs
            assign src_switch = 1'b0;
            assign src_sel    = '0;
            assign parent_idx = '0;
        end

        if (HAS_GATE) begin : g_gate_reg
            always_ff @(posedge clk) begin
                if (rst)
                    gate_req <= 1'b0;
                else if (we && cfg_addr_e'(addr) == ADDR_GATE)
                    gate_req <= wdata[0];
            end
        end else begin : g_no_gate_reg
            assign gate_req = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/clkdiv_src_mux.sv
module clkdiv_src_mux #(
    parameter int SEL_W   = 3,
    parameter bit HAS_MUX = 1'b1
) (
    input  logic                  prim_tick,
    input  logic [(1<<SEL_W)-1:0] aux_tick,
    input  logic                  src_switch,
    input  logic [SEL_W-1:0]      src_sel,
    output logic                  sel_tick
);
    generate
        if (HAS_MUX) begin : g_two_level
            logic aux_pick;
            assign aux_pick = aux_tick[src_sel];
            assign sel_tick = src_switch ? aux_pick : prim_tick;
        end else begin : g_primary_only
            assign sel_tick = prim_tick;
        end
    endgenerate
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [RATIO_W-1:0] ratio,
    output logic               div_clk
);
    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] ratio_q;
    logic               at_end;

    assign at_end = (cnt == ratio_q - RATIO_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            ratio_q <= RATIO_W'(1);
            div_clk <= 1'b0;
        end else if (tick) begin
            if (at_end) begin
                cnt     <= '0;
                ratio_q <= ratio;
                div_clk <= ~div_clk;
            end else begin
                cnt <= cnt + RATIO_W'(1);
            end
        end
    end
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate #(
    parameter bit HAS_GATE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic div_clk,
    input  logic gate_req,
    output logic clk_out
);
    generate
        if (HAS_GATE) begin : g_gate
            logic gate_q;
            always_ff @(posedge clk) begin
                if (rst)
                    gate_q <= 1'b0;
                else if (!div_clk)
                    gate_q <= gate_req;
            end
            assign clk_out = div_clk & gate_q;
        end else begin : g_open
            assign clk_out = div_clk;
        end
    endgenerate
endmodule

// File: rtl/clkdiv_cell.sv
module clkdiv_cell
    import clkdiv_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int DATA_W   = 8,
    parameter bit HAS_MUX  = 1'b1,
    parameter bit HAS_GATE = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    input  logic                  prim_tick,
    input  logic [(1<<SEL_W)-1:0] aux_tick,
    output logic                  clk_out,
    output logic [SEL_W:0]        parent_idx,
    output logic [RATIO_W-1:0]    eff_ratio
);
    logic             src_switch;
    logic [SEL_W-1:0] src_sel;
    div_ctl_t         div_ctl;
    logic             gate_req;
    logic             sel_tick;
    logic             div_clk;

    clkdiv_cfg_regs #(
        .SEL_W(SEL_W), .DATA_W(DATA_W), .HAS_MUX(HAS_MUX), .HAS_GATE(HAS_GATE)
    ) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .src_switch(src_switch), .src_sel(src_sel), .div_ctl(div_ctl),
        .gate_req(gate_req), .parent_idx(parent_idx)
    );

    clkdiv_src_mux #(.SEL_W(SEL_W), .HAS_MUX(HAS_MUX)) u_mux (
        .prim_tick(prim_tick), .aux_tick(aux_tick), .src_switch(src_switch),
        .src_sel(src_sel), .sel_tick(sel_tick)
    );

    assign eff_ratio = pick_ratio(div_ctl);

    clkdiv_counter u_div (
        .clk(clk), .rst(rst), .tick(sel_tick), .ratio(eff_ratio), .div_clk(div_clk)
    );

    clkdiv_gate #(.HAS_GATE(HAS_GATE)) u_gate (
        .clk(clk), .rst(rst), .div_clk(div_clk), .gate_req(gate_req), .clk_out(clk_out)
    );
endmodule

// File: rtl/clkdiv_cell_checker.sv
module clkdiv_cell_checker (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [1:0] cfg_addr,
    input logic [7:0] cfg_wdata,
    input logic [3:0] parent_idx,
    input logic [3:0] eff_ratio,
    input logic       clk_out,
    input logic       sel_tick,
    input logic       div_clk
);
    assert_index_load_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 2'd0 && cfg_wdata <= 8'd8) |=> parent_idx == $past(cfg_wdata[3:0]));

    assert_index_reject_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 2'd0 && cfg_wdata > 8'd8) |=> $stable(parent_idx));

    assert_div3_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 2'd1 && cfg_wdata[4]) |=> eff_ratio == 4'd3);

    assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 2'd1 && !cfg_wdata[4] && !cfg_wdata[3]) |=> eff_ratio == 4'd1);

    assert_hold_no_edge_R6: assert property (@(posedge clk) disable iff (rst)
        !sel_tick |=> $stable(div_clk));

    assert_no_cut_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_out) |-> $fell(div_clk));
endmodule

bind clkdiv_cell clkdiv_cell_checker u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .parent_idx(parent_idx), .eff_ratio(eff_ratio), .clk_out(clk_out),
    .sel_tick(sel_tick), .div_clk(div_clk)
);

// File: tb/clkdiv_cell_bench.sv
`timescale 1ns/1ps
module clkdiv_cell_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       prim_tick = 1'b1;
    logic [7:0] aux_tick = 8'd0;
    logic       clk_out;
    logic [3:0] parent_idx;
    logic [3:0] eff_ratio;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    clkdiv_cell u_clkdiv_cell (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .prim_tick(prim_tick), .aux_tick(aux_tick), .clk_out(clk_out),
        .parent_idx(parent_idx), .eff_ratio(eff_ratio)
    );

    // {divider word [8:4], expected ratio [3:0]}; word bits: [4] div3, [3] on, [2:0] code
    localparam logic [8:0] VEC [11] = '{
        {5'b01000, 4'd1}, {5'b01001, 4'd2}, {5'b01010, 4'd4}, {5'b01011, 4'd6},
        {5'b01100, 4'd8}, {5'b01101, 4'd12}, {5'b01110, 4'd1}, {5'b01111, 4'd1},
        {5'b00101, 4'd1}, {5'b11101, 4'd3}, {5'b10011, 4'd3}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // write launched at the current negedge without consuming sample time
    task automatic wr_now(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        fork
            begin @(posedge clk); #1 cfg_we = 1'b0; end
        join_none
    endtask

    task automatic sync_change();
        logic v;
        v = clk_out;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (clk_out != v) break;
        end
    endtask

    task automatic run_len(output int n);
        logic v;
        v = clk_out;
        n = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (clk_out != v) break;
            n++;
        end
    endtask

    task automatic count_changes(input int cycles, output int n);
        logic v;
        v = clk_out;
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (clk_out != v) n++;
            v = clk_out;
        end
    endtask

    task automatic sync_rise();
        sync_change();
        if (clk_out == 1'b0) sync_change();
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        int n2;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 parent_idx", int'(parent_idx), 0);
        chk("R1 eff_ratio", int'(eff_ratio), 1);
        count_changes(20, n);
        chk("R1 clk_out held low", int'(clk_out) + n, 0);

        // R2 index handling
        wr(2'd0, 8'd5);  chk("R2 index 5", int'(parent_idx), 5);
        wr(2'd0, 8'd8);  chk("R2 index 8", int'(parent_idx), 8);
        wr(2'd0, 8'd9);  chk("R2 index 9 ignored", int'(parent_idx), 8);
        wr(2'd0, 8'h13); chk("R2 upper bits ignored", int'(parent_idx), 8);
        wr(2'd0, 8'd0);  chk("R2 index 0", int'(parent_idx), 0);
        wr(2'd3, 8'hFF);
        chk("R2 spare addr index", int'(parent_idx), 0);
        chk("R2 spare addr ratio", int'(eff_ratio), 1);

        // R3 R4 R5 R6 vector walk on the primary source
        wr(2'd2, 8'd1);
        foreach (VEC[i]) begin
            logic [4:0] w;
            int e;
            string tag;
            w = VEC[i][8:4];
            e = int'(VEC[i][3:0]);
            tag = w[4] ? "R4" : (w[3] ? "R3" : "R5");
            wr(2'd1, {3'b000, w});
            chk(tag, int'(eff_ratio), e);
            sync_change();
            run_len(n);
            run_len(n);
            run_len(n2);
            chk("R6 level length", n, e);
            chk("R6 next level length", n2, e);
        end

        // R7 routing
        wr(2'd1, 8'b01001);
        wr(2'd0, 8'd3);
        prim_tick = 1'b0; aux_tick = 8'b0000_0100;
        sync_change(); run_len(n); run_len(n);
        chk("R7 aux[2] drives", n, 2);
        prim_tick = 1'b1; aux_tick = 8'b1111_1011;
        count_changes(30, n);
        chk("R7 unchosen ignored", n, 0);
        wr(2'd0, 8'd8);
        prim_tick = 1'b0; aux_tick = 8'b1000_0000;
        sync_change(); run_len(n); run_len(n);
        chk("R7 aux[7] drives", n, 2);
        wr(2'd0, 8'd0);
        prim_tick = 1'b1; aux_tick = 8'b0000_0000;
        sync_change(); run_len(n); run_len(n);
        chk("R7 primary drives", n, 2);

        // R8 ratio change waits for the current level
        sync_change();
        wr_now(2'd1, 8'b01101);
        run_len(n);
        run_len(n2);
        chk("R8 current level keeps old ratio", n, 2);
        chk("R8 next level uses new ratio", n2, 12);

        // R9 gate
        wr(2'd1, 8'b01010);
        wr(2'd2, 8'd0);
        repeat (10) @(negedge clk);
        count_changes(30, n);
        chk("R9 disabled held low", int'(clk_out) + n, 0);
        wr(2'd2, 8'd1);
        sync_rise();
        run_len(n);
        chk("R9 first high after enable", n, 4);
        sync_rise();
        wr_now(2'd2, 8'd0);
        run_len(n);
        chk("R9 high not cut by disable", n, 4);
        count_changes(30, n);
        chk("R9 low after disable", int'(clk_out) + n, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule